// File: doc/BRIEF.md
# Bit-Error Monitor with Event Interrupts

This block is the monitoring half of a receive bit-error-rate tester. A pattern synchronizer upstream compares each received payload bit against its local pattern and hands this block a strobe per valid bit, a strobe marking that bit as wrong, and a level telling whether it has lost lock. The block keeps two running counters, one for bits and one for errored bits. On an update request it copies both into host-visible snapshot registers and restarts the counters, so every snapshot covers exactly the interval since the previous update.

Alongside the counts, the block keeps three live status bits and four latched event flags. Each flag has its own enable. An active-low interrupt line, driven from a register, goes low while any enabled flag is set. A single global mode input picks how the host acknowledges flags. In one mode, reading the flag register clears the flags. In the other mode, the host clears each flag by writing 1 to its bit.

Top module: `bert_monitor`

## Requirements
- R1: A cycle with `pm_upd` high copies the running bit count to address 0 and the running error count to address 1, and restarts both running counters.
- R2: A bit whose `bit_vld` is high in the same cycle as `pm_upd` is counted in the new interval, not in the snapshot. An error strobe is counted only when `bit_vld` is also high.
- R3: Both running counters stop at all-ones and do not wrap. The bench builds a 6-bit bit counter (limit 63) and a 3-bit error counter (limit 7).
- R4: Address 2 reads the live status with no side effect. Bit 0 is high for the one cycle after an update. Bit 1 is high while the running error count is non-zero. Bit 2 follows `oos_in`, registered.
- R5: The flag register at address 3 holds four flags. Bit 0 sets on an update. Bit 1 sets on every errored valid bit. Bit 2 sets when the running error count goes from zero to non-zero. Bit 3 sets on either edge of the out-of-sync status. A flag that is set and cleared in the same cycle ends up set.
- R6: `irq_n` is registered. It is low exactly when some flag and its enable bit are both 1, and it changes at the same clock edge as the flags or enables.
- R7: With `ack_mode` at 0, a read of address 3 returns the flags and clears them all at that edge. Writes to address 3 have no effect in this mode.
- R8: With `ack_mode` at 1, reads of address 3 leave the flags unchanged. Writing 1 to a bit of address 3 clears that flag alone.
- R9: Address 4 is the read/write enable register, with the same bit order as the flags.
- R10: After reset all counters, snapshots, flags and enables are 0, the status reads 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A received payload bit is present this cycle |
| bit_err | input | 1 | The present bit mismatched the local pattern |
| oos_in | input | 1 | Pattern synchronizer is out of lock |
| pm_upd | input | 1 | Snapshot-and-restart request |
| ack_mode | input | 1 | 0: clear flags on read, 1: write one to clear |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 4 | Write data (flag and enable width) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with a 6-bit bit counter and a 3-bit error counter. These narrow widths put both saturation limits within a few dozen cycles. With them, a single table row can saturate one counter while the other keeps counting, and other rows can land exactly on a limit or pass beyond it. Directed sequences then cover an update that coincides with a bit, both acknowledge modes, masked and unmasked events, and both edges of loss of lock.

// File: rtl/bertm_pkg.sv
`timescale 1ns/1ps
package bertm_pkg;
  localparam int NUM_EV = 4;
  localparam int ADDR_W = 3;
  localparam int RD_W   = 32;

  localparam int EV_PM  = 0;
  localparam int EV_BIT = 1;
  localparam int EV_NZ  = 2;
  localparam int EV_OOS = 3;

  localparam logic [ADDR_W-1:0] A_BITS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ERRS = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIVE = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd4;

  // saturating increment: holds at cap
  function automatic logic [31:0] sat_next(logic [31:0] cur, logic inc, logic [31:0] cap);
    return (inc && cur != cap) ? cur + 32'd1 : cur;
  endfunction

  // new flag vector: clears first, then sets, so a set wins a collision
  function automatic logic [NUM_EV-1:0] flag_next(logic [NUM_EV-1:0] cur,
                                                  logic [NUM_EV-1:0] clr,
                                                  logic [NUM_EV-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/bertm_count.sv
`timescale 1ns/1ps
module bertm_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         upd,
  output logic [W-1:0] run,
  output logic [W-1:0] snap
);
  localparam logic [W-1:0] CAP = '1;

  logic [W-1:0] base;
  logic [W-1:0] run_nxt;

  always_comb begin
    base    = upd ? '0 : run;
    run_nxt = W'(bertm_pkg::sat_next(32'(base), inc, 32'(CAP)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      snap <= '0;
    end else begin
      run <= run_nxt;
      if (upd) snap <= run;
    end
  end
endmodule

// File: rtl/bertm_irq.sv
`timescale 1ns/1ps
module bertm_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_all,
  input  logic [N-1:0] clr_sel,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] enables,
  output logic         irq_n
);
  logic [N-1:0] clr;
  logic [N-1:0] flags_nxt;
  logic [N-1:0] en_nxt;

  always_comb begin
    clr       = clr_sel | {N{clr_all}};
    flags_nxt = bertm_pkg::flag_next(flags, clr, ev);
    en_nxt    = en_we ? en_wdata : enables;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
      irq_n   <= 1'b1;
    end else begin
      flags   <= flags_nxt;
      enables <= en_nxt;
      irq_n   <= ~|(flags_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/bert_monitor.sv
`timescale 1ns/1ps
module bert_monitor #(
  parameter int CNT_W = 32,
  parameter int ERR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_vld,
  input  logic                          bit_err,
  input  logic                          oos_in,
  input  logic                          pm_upd,
  input  logic                          ack_mode,
  input  logic [bertm_pkg::ADDR_W-1:0]  reg_addr,
  input  logic                          reg_rd,
  input  logic                          reg_wr,
  input  logic [bertm_pkg::NUM_EV-1:0]  reg_wdata,
  output logic [bertm_pkg::RD_W-1:0]    reg_rdata,
  output logic                          irq_n
);
  import bertm_pkg::*;

  logic [CNT_W-1:0]  run_bits, snap_bits;
  logic [ERR_W-1:0]  run_err, snap_err;
  logic              err_hit;
  logic              err_nz, err_nz_nxt;
  logic              oos_q, pm_done;
  logic [NUM_EV-1:0] ev, flags, enables, clr_sel;
  logic              clr_all, en_we, flag_sel;

  // event wires, named for the checker
  assign err_hit    = bit_vld & bit_err;
  assign err_nz     = |run_err;
  assign err_nz_nxt = pm_upd ? err_hit : (err_nz | err_hit);

  always_comb begin
    ev         = '0;
    ev[EV_PM]  = pm_upd;
    ev[EV_BIT] = err_hit;
    ev[EV_NZ]  = err_nz_nxt & ~err_nz;
    ev[EV_OOS] = oos_in ^ oos_q;
  end

  bertm_count #(.W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .inc(bit_vld), .upd(pm_upd),
    .run(run_bits), .snap(snap_bits)
  );

  bertm_count #(.W(ERR_W)) u_errs (
    .clk(clk), .rst_n(rst_n), .inc(err_hit), .upd(pm_upd),
    .run(run_err), .snap(snap_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oos_q   <= 1'b0;
      pm_done <= 1'b0;
    end else begin
      oos_q   <= oos_in;
      pm_done <= pm_upd;
    end
  end

  assign flag_sel = (reg_addr == A_FLAG);
  assign clr_all  = reg_rd & flag_sel & ~ack_mode;
  assign clr_sel  = (reg_wr & flag_sel & ack_mode) ? reg_wdata : '0;
  assign en_we    = reg_wr & (reg_addr == A_MASK);

  bertm_irq #(.N(NUM_EV)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr_all(clr_all), .clr_sel(clr_sel),
    .en_we(en_we), .en_wdata(reg_wdata), .flags(flags), .enables(enables),
    .irq_n(irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BITS:  reg_rdata = RD_W'(snap_bits);
      A_ERRS:  reg_rdata = RD_W'(snap_err);
      A_LIVE:  reg_rdata = RD_W'({oos_q, err_nz, pm_done});
      A_FLAG:  reg_rdata = RD_W'(flags);
      A_MASK:  reg_rdata = RD_W'(enables);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bertm_chk.sv
`timescale 1ns/1ps
module bertm_chk #(
  parameter int CNT_W = 32,
  parameter int ERR_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         pm_upd,
  input logic                         bit_vld,
  input logic                         bit_err,
  input logic                         ack_mode,
  input logic                         reg_rd,
  input logic                         reg_wr,
  input logic [bertm_pkg::ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]             run_bits,
  input logic [CNT_W-1:0]             snap_bits,
  input logic [ERR_W-1:0]             run_err,
  input logic [ERR_W-1:0]             snap_err,
  input logic                         err_nz,
  input logic [bertm_pkg::NUM_EV-1:0] ev,
  input logic [bertm_pkg::NUM_EV-1:0] flags,
  input logic [bertm_pkg::NUM_EV-1:0] enables,
  input logic                         irq_n
);
  assert_snap_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_upd |=> snap_bits == $past(run_bits));
  assert_snap_errs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_upd |=> snap_err == $past(run_err));
  assert_new_interval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_upd |=> run_bits == {{(CNT_W-1){1'b0}}, $past(bit_vld)});
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_upd && (&run_bits)) |=> (&run_bits));
  assert_err_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_err && !pm_upd) |=> err_nz);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !(|(flags & enables)));
  assert_cor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_mode && reg_rd && reg_addr == bertm_pkg::A_FLAG && ev == '0) |=> flags == '0);
  assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mode && !reg_wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind bert_monitor bertm_chk #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_upd(pm_upd), .bit_vld(bit_vld), .bit_err(bit_err),
  .ack_mode(ack_mode), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .run_bits(run_bits), .snap_bits(snap_bits), .run_err(run_err), .snap_err(snap_err),
  .err_nz(err_nz), .ev(ev), .flags(flags), .enables(enables), .irq_n(irq_n)
);

// File: tb/bert_monitor_test.sv
`timescale 1ns/1ps
module bert_monitor_test;
  localparam int CNT_W = 6;
  localparam int ERR_W = 3;
  localparam int NV    = 6;
  // each row: {bits sent, errors among them, expected bit snapshot, expected error snapshot}
  localparam logic [31:0] VEC [NV] = '{
    {8'd5,  8'd0,  8'd5,  8'd0},
    {8'd12, 8'd3,  8'd12, 8'd3},
    {8'd63, 8'd7,  8'd63, 8'd7},
    {8'd80, 8'd10, 8'd63, 8'd7},
    {8'd0,  8'd0,  8'd0,  8'd0},
    {8'd9,  8'd9,  8'd9,  8'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_err = 0, oos_in = 0, pm_upd = 0, ack_mode = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [3:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;
  int n_chk = 0, n_err = 0;
  logic [31:0] d;

  always #4 clk = ~clk;

  bert_monitor #(.CNT_W(CNT_W), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err), .oos_in(oos_in),
    .pm_upd(pm_upd), .ack_mode(ack_mode), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1; #1;
    v = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_upd();
    pm_upd = 1'b1; step(); pm_upd = 1'b0;
  endtask

  task automatic one_err();
    bit_vld = 1'b1; bit_err = 1'b1; step(); bit_vld = 1'b0; bit_err = 1'b0;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();

    // R10 reset state
    chk("R10 irq_n", 32'(irq_n), 32'd1);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R10 register", d, 32'd0);
    end

    // R1 / R3 table walk
    pulse_upd();
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][31:24]); k++) begin
        bit_vld = 1'b1; bit_err = (k < int'(VEC[i][23:16]));
        step();
      end
      bit_vld = 1'b0; bit_err = 1'b0;
      pulse_upd();
      rd(3'd0, d); chk("R1/R3 bit snapshot", d, {24'd0, VEC[i][15:8]});
      rd(3'd1, d); chk("R1/R3 error snapshot", d, {24'd0, VEC[i][7:0]});
    end

    // R2 bit coinciding with update belongs to next interval
    ack_mode = 1'b1;
    bit_vld = 1'b1; repeat (3) step();
    pm_upd = 1'b1; step(); pm_upd = 1'b0; bit_vld = 1'b0;
    rd(3'd0, d); chk("R2 first snapshot", d, 32'd3);
    pulse_upd();
    rd(3'd0, d); chk("R2 carried bit", d, 32'd1);
    bit_err = 1'b1; step(); bit_err = 1'b0;
    pulse_upd();
    rd(3'd1, d); chk("R2 error without valid", d, 32'd0);

    // R4 live status, R5 flag sources
    wr(3'd3, 4'hF);
    one_err();
    rd(3'd2, d); chk("R4 error live", d, 32'h2);
    rd(3'd2, d); chk("R4 read no side effect", d, 32'h2);
    rd(3'd3, d); chk("R5 bit+nonzero flags", d, 32'h6);
    oos_in = 1'b1; step();
    rd(3'd2, d); chk("R4 oos live", d, 32'h6);
    pulse_upd();
    rd(3'd2, d); chk("R4 update pulse", d, 32'h5);
    rd(3'd2, d); chk("R4 update pulse ends", d, 32'h4);
    rd(3'd3, d); chk("R5 all flags", d, 32'hF);

    // R8 write-one-to-clear
    wr(3'd3, 4'h2);
    rd(3'd3, d); chk("R8 single clear", d, 32'hD);
    rd(3'd3, d); chk("R8 read keeps flags", d, 32'hD);
    wr(3'd3, 4'hF);
    rd(3'd3, d); chk("R8 clear all", d, 32'h0);

    // R6 / R9 enables and irq
    one_err();
    chk("R6 masked event", 32'(irq_n), 32'd1);
    wr(3'd4, 4'h4);
    chk("R6 enable asserts irq", 32'(irq_n), 32'd0);
    rd(3'd4, d); chk("R9 enable readback", d, 32'h4);
    wr(3'd3, 4'h4);
    chk("R6 clear releases irq", 32'(irq_n), 32'd1);
    one_err();
    chk("R5 nonzero not re-raised", 32'(irq_n), 32'd1);
    rd(3'd3, d); chk("R5 only bit flag", d, 32'h2);

    // R7 clear-on-read
    ack_mode = 1'b0;
    wr(3'd3, 4'hF);
    rd(3'd3, d); chk("R7 write ignored", d, 32'h2);
    rd(3'd3, d); chk("R7 read cleared", d, 32'h0);
    wr(3'd4, 4'h2);
    one_err();
    chk("R6 bit error irq", 32'(irq_n), 32'd0);
    rd(3'd3, d); chk("R7 flags on read", d, 32'h2);
    chk("R7 irq released", 32'(irq_n), 32'd1);
    oos_in = 1'b0; step();
    rd(3'd3, d); chk("R5 oos falling edge", d, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule